// File: doc/BRIEF.md
# Lane Parallel Word Adapter

This block sits between one lane's internal stream of two-character lane words and a parallel pin bus whose shape is chosen by configuration inputs. In the ingress direction it gathers pin samples into lane words. In the egress direction it spreads lane words back out onto the pins. Three static inputs set the shape of the bus. `cfg_bypass` picks raw 10-bit code groups (1) or 8-bit characters with a control flag (0). `cfg_wide` picks two characters per pin sample (1) or one (0). `cfg_ddr` picks whether both halves of the word-clock period carry data (1) or only the first half (0).

Double-rate transfers are modelled with a single fast clock `clk` and a `phase` input that the system toggles every cycle. `phase` = 0 marks the first (rising) half of a word-clock period and `phase` = 1 marks the second (falling) half. Every register sits on `clk`. A lane word holds two 10-bit slots. Slot 0 is the earlier character and occupies word bits [9:0]; slot 1 occupies bits [19:10]. Inside a slot, bits [7:0] are the character and bits [9:8] are the side-band pair. In character mode, bit 8 is the control flag and bit 9 is always 0.

The transmit side is frequency-locked to the reference, so no rate-matching buffer is present. A fixed register stage of `PIPE_DEPTH` cycles follows ingress assembly. A one-character bus with only the first half used cannot carry the lane rate. That combination raises `cfg_err` and silences both directions.

Top module: `lane_word_adapter`

## Requirements
- R1: `cfg_err` is 1 exactly when `cfg_wide`=0 and `cfg_ddr`=0. While it is 1, `ig_valid`, `pin_out_vld` and `eg_ready` are 0 and `pin_out_data`/`pin_out_sb` are all zero.
- R2: With wide bus and single-edge timing, one word is assembled from each cycle that has `phase`=0 and `pin_in_vld`=1. Samples taken while `phase`=1 are ignored.
- R3: With wide bus and double-edge timing, one word is assembled from every cycle that has `pin_in_vld`=1, whatever the phase.
- R4: With the one-character bus (double-edge only), slot 0 comes from a valid sample at `phase`=0 and slot 1 from a valid sample in the very next cycle at `phase`=1. A `phase`=1 sample with no valid first half in the cycle before it produces no word.
- R5: Ingress slot format: slot 0 is taken from `pin_in_data[7:0]` with `pin_in_sb[1:0]`, and slot 1 from `pin_in_data[15:8]` with `pin_in_sb[3:2]`; the one-character bus uses only the low pins. In raw mode a slot is {side pair, byte} unchanged. In character mode a slot is {0, lower side bit, byte}, and the upper side bit is ignored.
- R6: `ig_valid` pulses once per assembled word, in order. It is high in the cycle that follows `PIPE_DEPTH` clock edges after the edge that sampled the word's last part (one cycle after assembly by default).
- R7: Wide egress: `eg_ready` is 1 in every cycle with double-edge timing, and only in `phase`=1 cycles with single-edge timing. A word taken (`eg_valid` and `eg_ready` both 1) drives both slots on the pins from the next cycle, with `pin_out_vld` high for one cycle (double-edge) or two cycles (single-edge).
- R8: One-character egress: `eg_ready` is 1 only in `phase`=1 cycles. A taken word drives slot 0 in the next cycle (`phase`=0) and slot 1 in the cycle after that, on `pin_out_data[7:0]`/`pin_out_sb[1:0]`. The other pins stay 0.
- R9: Egress slot format: in raw mode the side pair equals slot bits [9:8]. In character mode the upper side pin is 0, the lower one is slot bit 8, and slot bit 9 is ignored. Whenever `pin_out_vld` is 0, all pins are 0.
- R10: After synchronous reset, `ig_valid` and `pin_out_vld` are 0 and the egress pins are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one cycle per bus phase |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bypass | input | 1 | 1: raw 10-bit code groups; 0: characters with control flag |
| cfg_wide | input | 1 | 1: two characters per pin sample; 0: one |
| cfg_ddr | input | 1 | 1: both phases carry data; 0: first phase only |
| phase | input | 1 | 0 first half, 1 second half of the word-clock period |
| pin_in_data | input | 16 | Ingress character pins |
| pin_in_sb | input | 4 | Ingress side-band pins, one pair per character |
| pin_in_vld | input | 1 | Ingress pin sample is meaningful |
| ig_word | output | 20 | Assembled lane word |
| ig_valid | output | 1 | `ig_word` valid pulse |
| eg_word | input | 20 | Lane word to drive onto the pins |
| eg_valid | input | 1 | `eg_word` offered |
| eg_ready | output | 1 | Block takes a word this cycle |
| pin_out_data | output | 16 | Egress character pins |
| pin_out_sb | output | 4 | Egress side-band pins |
| pin_out_vld | output | 1 | Egress pins carry data |
| cfg_err | output | 1 | Illegal bus configuration |

## Verification
The hardest case to reach is an orphan second half on the one-character bus. This is a `phase`=1 sample with no valid first half, and it must vanish without shifting later pairs. Random gaps on `pin_in_vld` reach it now and then. A directed segment reaches it every time by asserting `pin_in_vld` only in `phase`=1 cycles. A second hard point is a wide single-edge word that must ignore its second-phase sample. Full-rate segments hold `pin_in_vld` high in every cycle, so each such sample would show up as an extra word.

// File: rtl/lwa_pkg.sv
package lwa_pkg;

    localparam int CHAR_W = 8;
    localparam int SIDE_W = 2;
    localparam int CODE_W = CHAR_W + SIDE_W;
    localparam int SLOTS  = 2;
    localparam int PIN_DW = CHAR_W * SLOTS;
    localparam int PIN_SW = SIDE_W * SLOTS;
    localparam int WORD_W = CODE_W * SLOTS;
    localparam int HOLD_W = $clog2(SLOTS + 1);

    typedef logic [CODE_W-1:0] code_t;

    // slot 0 is the earlier character and sits in the low bits
    typedef struct packed {
        code_t s1;
        code_t s0;
    } lword_t;

    typedef struct packed {
        logic [PIN_DW-1:0] data;
        logic [PIN_SW-1:0] side;
    } pins_t;

    typedef enum logic [1:0] {
        M_ILLEGAL   = 2'd0,
        M_WIDE_SDR  = 2'd1,
        M_WIDE_DDR  = 2'd2,
        M_SHORT_DDR = 2'd3
    } xfer_e;

    // character mode keeps only the control flag of the side pair
    function automatic code_t slot_mask(code_t c, logic bypass);
        code_t r;
        r = c;
        if (!bypass) r[CODE_W-1:CHAR_W+1] = '0;
        return r;
    endfunction

    function automatic lword_t unpack_wide(pins_t p, logic bypass);
        lword_t w;
        w.s0 = slot_mask({p.side[SIDE_W-1:0], p.data[CHAR_W-1:0]}, bypass);
        w.s1 = slot_mask({p.side[PIN_SW-1:SIDE_W], p.data[PIN_DW-1:CHAR_W]}, bypass);
        return w;
    endfunction

    function automatic pins_t pack_short(code_t c, logic bypass);
        pins_t p;
        code_t m;
        m = slot_mask(c, bypass);
        p = '0;
        p.data[CHAR_W-1:0] = m[CHAR_W-1:0];
        p.side[SIDE_W-1:0] = m[CODE_W-1:CHAR_W];
        return p;
    endfunction

    function automatic pins_t pack_wide(lword_t w, logic bypass);
        pins_t p;
        code_t m0;
        code_t m1;
        m0 = slot_mask(w.s0, bypass);
        m1 = slot_mask(w.s1, bypass);
        p.data = {m1[CHAR_W-1:0], m0[CHAR_W-1:0]};
        p.side = {m1[CODE_W-1:CHAR_W], m0[CODE_W-1:CHAR_W]};
        return p;
    endfunction

endpackage

// File: rtl/lwa_cfg_check.sv
module lwa_cfg_check
    import lwa_pkg::*;
(
    input  logic  cfg_wide,
    input  logic  cfg_ddr,
    output xfer_e mode,
    output logic  cfg_err
);

    always_comb begin
        unique case ({cfg_wide, cfg_ddr})
            2'b11:   mode = M_WIDE_DDR;
            2'b10:   mode = M_WIDE_SDR;
            2'b01:   mode = M_SHORT_DDR;
            default: mode = M_ILLEGAL;
        endcase
    end

    assign cfg_err = (mode == M_ILLEGAL);

endmodule

// File: rtl/lwa_ingress.sv
module lwa_ingress
    import lwa_pkg::*;
#(
    parameter int PIPE_DEPTH = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  xfer_e  mode,
    input  logic   bypass,
    input  logic   phase,
    input  pins_t  pin_i,
    input  logic   pin_vld,
    output lword_t word_o,
    output logic   valid_o
);

    localparam int LAST = PIPE_DEPTH;

    code_t  lo_c;
    lword_t wide_c;
    lword_t asm_w;
    logic   asm_v;
    code_t  half_q;
    logic   half_ok_q;
    logic   legal;

    lword_t pw [LAST+1];
    logic   pv [LAST+1];

    assign legal = (mode != M_ILLEGAL);

    always_comb begin
        lo_c   = slot_mask({pin_i.side[SIDE_W-1:0], pin_i.data[CHAR_W-1:0]}, bypass);
        wide_c = unpack_wide(pin_i, bypass);
        asm_w  = wide_c;
        asm_v  = 1'b0;
        unique case (mode)
            M_WIDE_SDR:  asm_v = pin_vld && !phase;
            M_WIDE_DDR:  asm_v = pin_vld;
            M_SHORT_DDR: begin
                asm_v = pin_vld && phase && half_ok_q;
                asm_w = '{s1: lo_c, s0: half_q};
            end
            default:     asm_v = 1'b0;
        endcase
    end

    // first half of a one-character pair, valid only into the next phase
    always_ff @(posedge clk) begin
        if (rst) begin
            half_q    <= '0;
            half_ok_q <= 1'b0;
        end else begin
            half_ok_q <= (mode == M_SHORT_DDR) && pin_vld && !phase;
            if (pin_vld && !phase) half_q <= lo_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pv[0] <= 1'b0;
        else     pv[0] <= asm_v && legal;
        pw[0] <= asm_w;
    end

    for (genvar g = 1; g <= LAST; g++) begin : g_pipe
        always_ff @(posedge clk) begin
            if (rst) pv[g] <= 1'b0;
            else     pv[g] <= pv[g-1] && legal;
            pw[g] <= pw[g-1];
        end
    end

    assign word_o  = pw[LAST];
    assign valid_o = pv[LAST] && legal;

    AST_WIDE_SDR_FIRST_PHASE: assert property (@(posedge clk) disable iff (rst)
        (pv[0] && $past(mode) == M_WIDE_SDR) |-> !$past(phase)); // R2

    AST_SHORT_PAIR_COMPLETE: assert property (@(posedge clk) disable iff (rst)
        (pv[0] && $past(mode) == M_SHORT_DDR) |-> ($past(phase) && $past(half_ok_q))); // R4

endmodule

// File: rtl/lwa_egress.sv
module lwa_egress
    import lwa_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  xfer_e  mode,
    input  logic   bypass,
    input  logic   phase,
    input  lword_t word_i,
    input  logic   valid_i,
    output logic   ready_o,
    output pins_t  pin_o,
    output logic   pin_vld_o
);

    lword_t            cur_q;
    logic [HOLD_W-1:0] cnt_q;
    logic              sel_q;
    logic              take;

    assign ready_o = (mode == M_WIDE_DDR) ||
                     (((mode == M_WIDE_SDR) || (mode == M_SHORT_DDR)) && phase);
    assign take    = ready_o && valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            cnt_q <= '0;
            sel_q <= 1'b0;
        end else if (mode == M_ILLEGAL) begin
            cnt_q <= '0;
            sel_q <= 1'b0;
        end else if (take) begin
            cur_q <= word_i;
            cnt_q <= (mode == M_WIDE_DDR) ? HOLD_W'(1) : HOLD_W'(SLOTS);
            sel_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - HOLD_W'(1);
            sel_q <= 1'b1;
        end
    end

    always_comb begin
        pin_vld_o = (cnt_q != '0) && (mode != M_ILLEGAL);
        pin_o     = '0;
        if (pin_vld_o) begin
            if (mode == M_SHORT_DDR) pin_o = pack_short(sel_q ? cur_q.s1 : cur_q.s0, bypass);
            else                     pin_o = pack_wide(cur_q, bypass);
        end
    end

    AST_SHORT_SECOND_SLOT: assert property (@(posedge clk) disable iff (rst)
        (pin_vld_o && !sel_q && mode == M_SHORT_DDR)
        |=> ((pin_vld_o && sel_q) || mode != M_SHORT_DDR)); // R8

    AST_IDLE_PINS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !pin_vld_o |-> (pin_o == '0)); // R9

endmodule

// File: rtl/lane_word_adapter.sv
module lane_word_adapter
    import lwa_pkg::*;
#(
    parameter int PIPE_DEPTH = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_bypass,
    input  logic              cfg_wide,
    input  logic              cfg_ddr,
    input  logic              phase,
    input  logic [PIN_DW-1:0] pin_in_data,
    input  logic [PIN_SW-1:0] pin_in_sb,
    input  logic              pin_in_vld,
    output logic [WORD_W-1:0] ig_word,
    output logic              ig_valid,
    input  logic [WORD_W-1:0] eg_word,
    input  logic              eg_valid,
    output logic              eg_ready,
    output logic [PIN_DW-1:0] pin_out_data,
    output logic [PIN_SW-1:0] pin_out_sb,
    output logic              pin_out_vld,
    output logic              cfg_err
);

    xfer_e  mode;
    pins_t  pin_in;
    pins_t  pin_out;
    lword_t ig_w;

    assign pin_in = '{data: pin_in_data, side: pin_in_sb};

    lwa_cfg_check u_cfg (
        .cfg_wide (cfg_wide),
        .cfg_ddr  (cfg_ddr),
        .mode     (mode),
        .cfg_err  (cfg_err)
    );

    lwa_ingress #(.PIPE_DEPTH(PIPE_DEPTH)) u_ig (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .bypass  (cfg_bypass),
        .phase   (phase),
        .pin_i   (pin_in),
        .pin_vld (pin_in_vld),
        .word_o  (ig_w),
        .valid_o (ig_valid)
    );

    lwa_egress u_eg (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .bypass    (cfg_bypass),
        .phase     (phase),
        .word_i    (lword_t'(eg_word)),
        .valid_i   (eg_valid),
        .ready_o   (eg_ready),
        .pin_o     (pin_out),
        .pin_vld_o (pin_out_vld)
    );

    assign ig_word      = ig_w;
    assign pin_out_data = pin_out.data;
    assign pin_out_sb   = pin_out.side;

    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!ig_valid && !pin_out_vld && !eg_ready)); // R1

endmodule

// File: tb/tb_lane_word_adapter.sv
module tb_lane_word_adapter;

    localparam int CLK_PERIOD = 10;
    localparam int PIPE       = 1;

    typedef struct packed {
        logic        vld;
        logic [15:0] d;
        logic [3:0]  s;
    } pexp_t;

    typedef struct packed {
        logic [31:0] due;
        logic [19:0] w;
    } iexp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_bypass = 1'b0;
    logic        cfg_wide = 1'b1;
    logic        cfg_ddr = 1'b1;
    logic        phase = 1'b0;
    logic [15:0] pin_in_data = '0;
    logic [3:0]  pin_in_sb = '0;
    logic        pin_in_vld = 1'b0;
    logic [19:0] ig_word;
    logic        ig_valid;
    logic [19:0] eg_word = '0;
    logic        eg_valid = 1'b0;
    logic        eg_ready;
    logic [15:0] pin_out_data;
    logic [3:0]  pin_out_sb;
    logic        pin_out_vld;
    logic        cfg_err;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    iexp_t       q[$];
    pexp_t       cur_exp = '0;
    pexp_t       pend = '0;
    logic        have = 1'b0;
    logic [9:0]  half = '0;

    lane_word_adapter #(.PIPE_DEPTH(PIPE)) dut (
        .clk(clk), .rst(rst),
        .cfg_bypass(cfg_bypass), .cfg_wide(cfg_wide), .cfg_ddr(cfg_ddr), .phase(phase),
        .pin_in_data(pin_in_data), .pin_in_sb(pin_in_sb), .pin_in_vld(pin_in_vld),
        .ig_word(ig_word), .ig_valid(ig_valid),
        .eg_word(eg_word), .eg_valid(eg_valid), .eg_ready(eg_ready),
        .pin_out_data(pin_out_data), .pin_out_sb(pin_out_sb), .pin_out_vld(pin_out_vld),
        .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [9:0] bslot(input logic [7:0] ch, input logic [1:0] sb);
        return cfg_bypass ? {sb, ch} : {1'b0, sb[0], ch};
    endfunction

    function automatic logic [1:0] oside(input logic [1:0] pair);
        return cfg_bypass ? pair : {1'b0, pair[0]};
    endfunction

    function automatic pexp_t pshort(input logic [9:0] c);
        pexp_t r;
        r.vld = 1'b1;
        r.d   = {8'h00, c[7:0]};
        r.s   = {2'b00, oside(c[9:8])};
        return r;
    endfunction

    function automatic pexp_t pwide(input logic [19:0] w);
        pexp_t r;
        r.vld = 1'b1;
        r.d   = {w[17:10], w[7:0]};
        r.s   = {oside(w[19:18]), oside(w[9:8])};
        return r;
    endfunction

    task automatic observe();
        bit    ill;
        bit    want;
        string t;
        ill = !cfg_wide && !cfg_ddr;
        chk(cfg_err == ill, "R1", "cfg_err", 32'(cfg_err), 32'(ill));
        want = (q.size() > 0) && (q[0].due == cyc);
        chk(ig_valid == want, ill ? "R1" : "R6", "ig_valid", 32'(ig_valid), 32'(want));
        if (want) begin
            if (ig_valid) begin
                t = cfg_wide ? (cfg_ddr ? "R3 R5" : "R2 R5") : "R4 R5";
                chk(ig_word == q[0].w, t, "ig_word", 32'(ig_word), 32'(q[0].w));
            end
            void'(q.pop_front());
        end
        while (q.size() > 0 && q[0].due < cyc) void'(q.pop_front());
        t = ill ? "R1" : (cfg_wide ? "R7 R9" : "R8 R9");
        chk(pin_out_vld == cur_exp.vld, t, "pin_out_vld", 32'(pin_out_vld), 32'(cur_exp.vld));
        chk({pin_out_data, pin_out_sb} == {cur_exp.d, cur_exp.s}, t, "pins",
            32'({pin_out_data, pin_out_sb}), 32'({cur_exp.d, cur_exp.s}));
    endtask

    task automatic step(input bit act, input int pat, input bit bp, input bit wd, input bit dd);
        logic [9:0]  lo;
        logic [9:0]  hi;
        logic [31:0] e;
        bit          ill;
        bit          rdy;
        bit          take;
        @(negedge clk);
        observe();
        cfg_bypass = bp;
        cfg_wide   = wd;
        cfg_ddr    = dd;
        phase      = ~phase;
        pin_in_data = 16'($urandom);
        pin_in_sb   = 4'($urandom);
        case (pat)
            0:       pin_in_vld = act && ($urandom_range(0, 3) != 0);
            1:       pin_in_vld = act && phase;
            default: pin_in_vld = act;
        endcase
        eg_word  = 20'($urandom);
        eg_valid = act && ($urandom_range(0, 4) != 0);
        #1;
        ill = !wd && !dd;
        rdy = !ill && ((wd && dd) || phase);
        chk(eg_ready == rdy, ill ? "R1" : (wd ? "R7" : "R8"), "eg_ready", 32'(eg_ready), 32'(rdy));
        e  = cyc + 1;
        lo = bslot(pin_in_data[7:0], pin_in_sb[1:0]);
        hi = bslot(pin_in_data[15:8], pin_in_sb[3:2]);
        // ingress reference
        if (ill) begin
            have = 1'b0;
        end else if (wd) begin
            have = 1'b0;
            if (pin_in_vld && (dd || !phase)) q.push_back('{e + PIPE, {hi, lo}});
        end else if (!phase) begin
            have = pin_in_vld;
            half = lo;
        end else begin
            if (pin_in_vld && have) q.push_back('{e + PIPE, {lo, half}});
            have = 1'b0;
        end
        // egress reference
        take = eg_valid && rdy;
        if (ill) begin
            cur_exp = '0;
            pend    = '0;
        end else if (take) begin
            if (wd && dd) begin
                cur_exp = pwide(eg_word);
                pend    = '0;
            end else if (wd) begin
                cur_exp = pwide(eg_word);
                pend    = pwide(eg_word);
            end else begin
                cur_exp = pshort(eg_word[9:0]);
                pend    = pshort(eg_word[19:10]);
            end
        end else begin
            cur_exp = pend;
            pend    = '0;
        end
    endtask

    task automatic run_seg(input bit bp, input bit wd, input bit dd, input int n, input int pat);
        repeat (n) step(1'b1, pat, bp, wd, dd);
        repeat (6) step(1'b0, 0, bp, wd, dd);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(ig_valid == 1'b0, "R10", "ig_valid after reset", 32'(ig_valid), 32'd0);
        chk(pin_out_vld == 1'b0, "R10", "pin_out_vld after reset", 32'(pin_out_vld), 32'd0);
        chk({pin_out_data, pin_out_sb} == '0, "R10", "pins after reset",
            32'({pin_out_data, pin_out_sb}), 32'd0);
        rst = 1'b0;
        for (int b = 0; b < 2; b++) begin
            for (int w = 0; w < 2; w++) begin
                for (int d = 0; d < 2; d++) begin
                    run_seg(b[0], w[0], d[0], 300, 0);
                end
            end
        end
        // R4: only second-phase samples, no word may appear
        run_seg(1'b0, 1'b0, 1'b1, 40, 1);
        run_seg(1'b1, 1'b0, 1'b1, 40, 1);
        // full-rate streams in each legal shape
        run_seg(1'b1, 1'b0, 1'b1, 40, 2);
        run_seg(1'b1, 1'b1, 1'b1, 40, 2);
        run_seg(1'b0, 1'b1, 1'b0, 40, 2);   // R2: phase-1 samples must be dropped
        run_seg(1'b0, 1'b0, 1'b0, 20, 2);   // R1 under full activity
        run_seg(1'b0, 1'b1, 1'b1, 20, 2);
        summary();
        $finish;
    end

endmodule